// File: doc/BRIEF.md
# Two-Level Carry Look-Ahead Adder

This block is a purely combinational 16-bit adder. It adds two 16-bit operands and a single carry input, and it returns a 16-bit sum and a carry output. It is meant to sit directly in a datapath, for example in the adder of an arithmetic unit. It has no clock, no registers and no handshake. Its outputs follow its inputs within one combinational settling time.

Internally the word is cut into four 4-bit slices. Each slice forms a per-bit generate term, which is the AND of the operand bits, and a per-bit propagate term, which is the XOR of the operand bits. From these it resolves all of its internal carries at once with look-ahead equations. Each sum bit is the propagate term XORed with that bit's incoming carry. Each slice also reports a group generate and a group propagate. A second look-ahead unit uses the same equations, fed with these group terms and the external carry input. It produces the carry into every slice, and the final carry output, in parallel. So no carry ever ripples from one slice to the next.

The operand width and the slice width are parameters. The second-level unit adapts to the number of slices these imply.

Top module: `cla_adder16`

## Requirements
- R1: `sum_out` equals the low 16 bits of `op_a + op_b + carry_in` for every input combination.
- R2: `carry_out` equals bit 16 of the 17-bit result of `op_a + op_b + carry_in`.
- R3: The block holds no state: applying an input combination again, after other inputs, gives the same outputs as the first time.
- R4: When every bit propagates (`op_b` is the bitwise complement of `op_a`), `carry_in` = 1 gives `sum_out` = 0x0000 and `carry_out` = 1, and `carry_in` = 0 gives `sum_out` = 0xFFFF and `carry_out` = 0. A slice whose group propagate is set passes its carry input to its carry output.
- R5: All-ones plus one (0xFFFF + 0x0001, `carry_in` = 0) gives `sum_out` = 0x0000 and `carry_out` = 1.
- R6: Alternating patterns add correctly: 0xAAAA + 0x5555 gives 0xFFFF with `carry_out` 0 when `carry_in` = 0, and 0x0000 with `carry_out` 1 when `carry_in` = 1. 0xAAAA + 0xAAAA gives 0x5554 with `carry_out` 1.
- R7: A slice whose group generate is set delivers a carry into the next slice whatever its own carry input is. For example, 0x000F + 0x0001 gives 0x0010, and 0xF000 + 0x1000 gives 0x0000 with `carry_out` 1.
- R8: Every slice carry and the final carry from the second-level unit equal the group generate of the slice below, ORed with the AND of that slice's group propagate and its carry input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Low 16 bits of the sum |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The hardest case has two things happening in the same evaluation: one slice generates a carry, and every slice above it only propagates. The generated carry must then cross several slices through the second-level unit. A carry input that must cross all four propagating slices is a similar case. The sweep provokes both by replicating an 8-bit operand pair into both halves of the word, so each generate/propagate mix in the low slices recurs in the upper slices with the carry arriving from below. Directed vectors add complement pairs, all-ones plus one and single-slice generates. Every result is judged against a 17-bit arithmetic sum computed in the bench.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned CLA_WORD_W  = 16;
  localparam int unsigned CLA_SLICE_W = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } cla_grp_t;
endpackage

// File: rtl/cla_pg_gen.sv
module cla_pg_gen #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] gen,
  output logic [W-1:0] prop
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen[i]  = a[i] & b[i];
    assign prop[i] = a[i] ^ b[i];
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen,
  input  logic [N-1:0] prop,
  input  logic         cin,
  output logic [N:0]   carry,
  output logic         grp_gen,
  output logic         grp_prop
);
  // Flat sum-of-products: each carry is an OR of terms, one per source,
  // so no carry depends on another carry.
  always_comb begin
    carry[0] = cin;
    for (int i = 0; i < N; i++) begin
      logic acc;
      logic chain;
      chain = cin;
      for (int k = 0; k <= i; k++) chain = chain & prop[k];
      acc = chain;
      for (int j = 0; j <= i; j++) begin
        logic term;
        term = gen[j];
        for (int k = j + 1; k <= i; k++) term = term & prop[k];
        acc = acc | term;
      end
      carry[i+1] = acc;
    end
  end

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      logic term;
      term = gen[j];
      for (int k = j + 1; k < N; k++) term = term & prop[k];
      acc = acc | term;
    end
    grp_gen  = acc;
    grp_prop = &prop;
  end

  // R8: the parallel equations must agree with the recursive carry form.
  for (genvar i = 0; i < N; i++) begin : g_chk
    always_comb begin
      if (!$isunknown({gen, prop, cin})) begin
        a_r8_carry_recurrence: assert (carry[i+1] == (gen[i] | (prop[i] & carry[i])))
          else $error("carry %0d breaks recurrence", i + 1);
      end
    end
  end
endmodule

// File: rtl/cla_slice.sv
module cla_slice #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output cla_pkg::cla_grp_t grp
);
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:0]   carry;
  logic         g_grp;
  logic         p_grp;

  cla_pg_gen #(.W(W)) u_pg (
    .a    (a),
    .b    (b),
    .gen  (gen),
    .prop (prop)
  );

  cla_lookahead #(.N(W)) u_la (
    .gen      (gen),
    .prop     (prop),
    .cin      (cin),
    .carry    (carry),
    .grp_gen  (g_grp),
    .grp_prop (p_grp)
  );

  assign sum      = prop ^ carry[W-1:0];
  assign grp.gen  = g_grp;
  assign grp.prop = p_grp;

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      a_r4_group_passes_cin: assert (!p_grp || (carry[W] == cin))
        else $error("propagating slice did not pass its carry");
      a_r7_group_makes_carry: assert (!g_grp || carry[W])
        else $error("generating slice produced no carry");
    end
  end
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
  parameter int unsigned WIDTH   = cla_pkg::CLA_WORD_W,
  parameter int unsigned SLICE_W = cla_pkg::CLA_SLICE_W
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  localparam int unsigned NSLICE = WIDTH / SLICE_W;

  cla_pkg::cla_grp_t [NSLICE-1:0] slice_grp;
  logic [NSLICE-1:0] sg;
  logic [NSLICE-1:0] sp;
  logic [NSLICE:0]   slice_carry;
  logic              top_gen;
  logic              top_prop;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    cla_slice #(.W(SLICE_W)) u_slice (
      .a   (op_a[s*SLICE_W +: SLICE_W]),
      .b   (op_b[s*SLICE_W +: SLICE_W]),
      .cin (slice_carry[s]),
      .sum (sum_out[s*SLICE_W +: SLICE_W]),
      .grp (slice_grp[s])
    );
    assign sg[s] = slice_grp[s].gen;
    assign sp[s] = slice_grp[s].prop;
  end

  cla_lookahead #(.N(NSLICE)) u_level2 (
    .gen      (sg),
    .prop     (sp),
    .cin      (carry_in),
    .carry    (slice_carry),
    .grp_gen  (top_gen),
    .grp_prop (top_prop)
  );

  assign carry_out = slice_carry[NSLICE];

  always_comb begin
    logic [WIDTH:0] ref_sum;
    ref_sum = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    if (!$isunknown({op_a, op_b, carry_in})) begin
      a_r1_sum_matches: assert (sum_out == ref_sum[WIDTH-1:0])
        else $error("sum mismatch");
      a_r2_cout_matches: assert (carry_out == ref_sum[WIDTH])
        else $error("carry out mismatch");
      a_r2_cout_from_word_terms: assert (carry_out == (top_gen | (top_prop & carry_in)))
        else $error("carry out disagrees with word group terms");
    end
  end
endmodule

// File: tb/cla_adder16_tb.sv
module cla_adder16_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        carry_in = 1'b0;
  logic [15:0] sum_out;
  logic        carry_out;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cla_adder16 u_dut (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out)
  );

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c,
                       input string tag);
    logic [16:0] exp;
    @(negedge clk);
    op_a = a; op_b = b; carry_in = c;
    #1;
    exp = {1'b0, a} + {1'b0, b} + {16'd0, c};
    vectors++;
    if (sum_out !== exp[15:0]) begin
      fails++;
      $display("FAIL %s/R1 sum %h+%h+%0d: got %h expected %h", tag, a, b, c, sum_out, exp[15:0]);
    end
    if (carry_out !== exp[16]) begin
      fails++;
      $display("FAIL %s/R2 cout %h+%h+%0d: got %0d expected %0d", tag, a, b, c, carry_out, exp[16]);
    end
  endtask

  task automatic expect_fixed(input logic [15:0] a, input logic [15:0] b, input logic c,
                              input logic [15:0] es, input logic ec, input string tag);
    @(negedge clk);
    op_a = a; op_b = b; carry_in = c;
    #1;
    vectors++;
    if (sum_out !== es || carry_out !== ec) begin
      fails++;
      $display("FAIL %s %h+%h+%0d: got %h/%0d expected %h/%0d", tag, a, b, c,
               sum_out, carry_out, es, ec);
    end
  endtask

  initial begin
    #1;
    // Reset-free start: first vector must already be correct (R1, R2).
    apply(16'h0000, 16'h0000, 1'b0, "R1");
    // R5: all ones plus one
    expect_fixed(16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, "R5");
    expect_fixed(16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, "R5");
    // R4: full propagate, carry in crosses every slice
    expect_fixed(16'h1234, 16'hEDCB, 1'b1, 16'h0000, 1'b1, "R4");
    expect_fixed(16'h1234, 16'hEDCB, 1'b0, 16'hFFFF, 1'b0, "R4");
    expect_fixed(16'h0F0F, 16'hF0F0, 1'b1, 16'h0000, 1'b1, "R4");
    // R6: alternating patterns
    expect_fixed(16'hAAAA, 16'h5555, 1'b0, 16'hFFFF, 1'b0, "R6");
    expect_fixed(16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1, "R6");
    expect_fixed(16'hAAAA, 16'hAAAA, 1'b0, 16'h5554, 1'b1, "R6");
    expect_fixed(16'h5555, 16'h5555, 1'b1, 16'hAAAB, 1'b0, "R6");
    // R7: a generating slice feeds the next one
    expect_fixed(16'h000F, 16'h0001, 1'b0, 16'h0010, 1'b0, "R7");
    expect_fixed(16'h00F0, 16'h0010, 1'b0, 16'h0100, 1'b0, "R7");
    expect_fixed(16'h0F00, 16'h0100, 1'b0, 16'h1000, 1'b0, "R7");
    expect_fixed(16'hF000, 16'h1000, 1'b0, 16'h0000, 1'b1, "R7");
    expect_fixed(16'hFFF8, 16'h0008, 1'b0, 16'h0000, 1'b1, "R7");
    // R8: slice carries visible through sums of mixed generate/propagate
    expect_fixed(16'h0FF8, 16'h0008, 1'b0, 16'h1000, 1'b0, "R8");
    expect_fixed(16'h7FFF, 16'h0000, 1'b1, 16'h8000, 1'b0, "R8");
    // Near-exhaustive sweep: byte pair replicated into both halves (R1, R2, R8)
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++)
          apply({a[7:0], a[7:0]}, {b[7:0], b[7:0]}, c[0], "R8");
    // R3: no memory of earlier inputs
    expect_fixed(16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1, "R3");
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      r = $urandom;
      apply(r[15:0], r[31:16], r[0] ^ r[17], "R1");
    end
    expect_fixed(16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1, "R3");
    expect_fixed(16'h000F, 16'h0001, 1'b0, 16'h0010, 1'b0, "R3");
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < WATCHDOG; cyc++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", WATCHDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule